// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block accepts a two-channel serial audio stream made of a bit clock, a frame clock and one data line, all of them asynchronous to the local master clock. It recovers one left and one right sample per frame. The three incoming lines are brought into the master-clock domain, and the rising edges of the bit clock are found there. Each level of the frame clock marks one channel half of 32 bit slots. A change in the frame-clock level starts a new half.

The justification mode and the word length are chosen at run time through two static selection inputs. One shift path handles all three modes and all four lengths. The word from each completed half is sign-extended to 24 bits. It is presented together with a one-cycle valid strobe and a flag that tells whether the sample is left or right. A new selection does not act at once. It is applied only at the next frame-clock edge that opens a left half.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is active and directly after it, `smp_o` is zero and `smp_valid_o` and `smp_right_o` are low.
- R2: With `fmt_i` = 0 (I2S-style), the MSB is in bit slot 1 counted from the frame-clock edge, where slot 0 is the first bit-clock rise after the edge. A low frame clock means left.
- R3: With `fmt_i` = 1 (left-justified), the MSB is in slot 0 and a high frame clock means left.
- R4: With `fmt_i` = 2 (right-justified), the LSB is in slot 31, so the MSB is in slot 32 minus the word length. A high frame clock means left.
- R5: `wlen_i` selects the word length: 0 = 16, 1 = 18, 2 = 20, 3 = 24 bits, sent MSB first. The output is the word sign-extended to 24 bits.
- R6: Data bits in slots outside the selected word window have no effect on the output.
- R7: A half's word appears with `smp_valid_o` high for exactly one cycle. This happens 3 master-clock cycles after the bit-clock rise that opens the next half. `smp_right_o` is high for a right-channel word, and `smp_o` holds its value between strobes.
- R8: A new `fmt_i`/`wlen_i` value is taken at the first frame-clock edge after reset, and after that only at an edge that enters the left level of the format currently in use. Halves before that edge are decoded with the old selection.
- R9: No word is output for the half that is running when reset ends. The first strobe carries the half that follows the first frame-clock transition.
- R10: `fmt_i` = 3 behaves exactly like `fmt_i` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| fclk_i | input | 1 | Frame clock, one level per channel half (asynchronous) |
| sdata_i | input | 1 | Serial data, changed on the bit-clock falling edge |
| fmt_i | input | 2 | Justification select (0/3 I2S-style, 1 left, 2 right) |
| wlen_i | input | 2 | Word-length select (16/18/20/24) |
| smp_o | output | 24 | Sign-extended received sample |
| smp_valid_o | output | 1 | One-cycle strobe for a new sample |
| smp_right_o | output | 1 | High when the sample belongs to the right channel |

## Verification
A word is due on the third master-clock cycle after the bench raises the bit clock for slot 0 of the next half. That delay comes from two synchronizer stages and one output register. When the bench drives that rise, its model records the exact due cycle. On every clock the bench samples the outputs on the falling edge. A strobe is expected only in that one cycle, and a strobe in any other cycle is a failure. The junk bits outside each word window and the changes of selection at edges that must not load it are both checked through the values that arrive at their due cycles.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;

   typedef enum logic [1:0] {
      JUST_I2S   = 2'd0,
      JUST_LEFT  = 2'd1,
      JUST_RIGHT = 2'd2,
      JUST_ALT   = 2'd3
   } just_e;

   // word length in bits for a length select code
   function automatic int unsigned word_bits(input logic [1:0] sel);
      case (sel)
         2'd0:    return 16;
         2'd1:    return 18;
         2'd2:    return 20;
         default: return 24;
      endcase
   endfunction

   // frame-clock level that denotes the left channel
   function automatic logic left_level(input logic [1:0] fmt);
      return (fmt == JUST_LEFT) || (fmt == JUST_RIGHT);
   endfunction

   // slot index of the MSB within a half
   function automatic int unsigned msb_slot(input logic [1:0] fmt,
                                            input int unsigned bits,
                                            input int unsigned slots);
      case (fmt)
         JUST_LEFT:  return 0;
         JUST_RIGHT: return slots - bits;
         default:    return 1;
      endcase
   endfunction

endpackage

// File: rtl/pcmrx_sync.sv
module pcmrx_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/pcmrx_framer.sv
module pcmrx_framer #(
   parameter int SLOTS  = 32,
   parameter int SLOT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_rise_i,
   input  logic              fclk_s_i,
   output logic              edge_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic              lvl_prev_o,
   output logic              armed_o
);

   logic              prev_vld;
   logic              lvl_q;
   logic              armed_q;
   logic [SLOT_W-1:0] slot_q;

   assign edge_o     = bit_rise_i && prev_vld && (fclk_s_i != lvl_q);
   assign slot_o     = edge_o ? '0 : ((slot_q == '1) ? slot_q : slot_q + 1'b1);
   assign lvl_prev_o = lvl_q;
   assign armed_o    = armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_vld <= 1'b0;
         lvl_q    <= 1'b0;
         armed_q  <= 1'b0;
         slot_q   <= '1;
      end else if (bit_rise_i) begin
         prev_vld <= 1'b1;
         lvl_q    <= fclk_s_i;
         slot_q   <= slot_o;
         if (edge_o) armed_q <= 1'b1;
      end
   end

   AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> armed_q); // R9

endmodule

// File: rtl/pcmrx_shift.sv
module pcmrx_shift
   import pcmrx_pkg::*;
#(
   parameter int OUT_W  = 24,
   parameter int SLOTS  = 32,
   parameter int SLOT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_rise_i,
   input  logic              edge_i,
   input  logic              armed_i,
   input  logic              sdata_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic              lvl_prev_i,
   input  logic [1:0]        cap_fmt_i,
   input  logic [1:0]        cap_wlen_i,
   input  logic [1:0]        emit_fmt_i,
   input  logic [1:0]        emit_wlen_i,
   output logic [OUT_W-1:0]  smp_o,
   output logic              valid_o,
   output logic              right_o
);

   logic [OUT_W-1:0] sh_q;
   logic             in_win;
   int unsigned      cap_bits;
   int unsigned      first;
   int unsigned      slot_u;

   function automatic logic [OUT_W-1:0] sext(input logic [OUT_W-1:0] v,
                                             input int unsigned b);
      logic [OUT_W-1:0] r;
      for (int i = 0; i < OUT_W; i++)
         r[i] = (i < b) ? v[i] : v[b-1];
      return r;
   endfunction

   always_comb begin
      cap_bits = word_bits(cap_wlen_i);
      first    = msb_slot(cap_fmt_i, cap_bits, SLOTS);
      slot_u   = {{(32-SLOT_W){1'b0}}, slot_i};
      in_win   = (slot_u >= first) && (slot_u < first + cap_bits);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q    <= '0;
         smp_o   <= '0;
         valid_o <= 1'b0;
         right_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (bit_rise_i) begin
            if (in_win) sh_q <= {sh_q[OUT_W-2:0], sdata_i};
            if (edge_i && armed_i) begin
               smp_o   <= sext(sh_q, word_bits(emit_wlen_i));
               valid_o <= 1'b1;
               right_o <= (lvl_prev_i != left_level(emit_fmt_i));
            end
         end
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R7
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(smp_o) && $stable(right_o)); // R7

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
   import pcmrx_pkg::*;
#(
   parameter int OUT_W      = 24,
   parameter int SLOTS_HALF = 32,
   parameter int SYNC_STG   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_i,
   input  logic             fclk_i,
   input  logic             sdata_i,
   input  logic [1:0]       fmt_i,
   input  logic [1:0]       wlen_i,
   output logic [OUT_W-1:0] smp_o,
   output logic             smp_valid_o,
   output logic             smp_right_o
);

   localparam int SLOT_W = $clog2(SLOTS_HALF) + 1;
   localparam int MAXLEN = 24;

   if (OUT_W < MAXLEN) begin : g_chk_w
      $error("OUT_W must hold the longest word");
   end
   if (SLOTS_HALF <= MAXLEN) begin : g_chk_s
      $error("SLOTS_HALF must exceed the longest word");
   end
   if (SYNC_STG < 2) begin : g_chk_y
      $error("SYNC_STG must be at least 2");
   end

   logic [2:0]        sync_q;
   logic              bclk_d;
   logic              bit_rise;
   logic              frm_edge;
   logic [SLOT_W-1:0] frm_slot;
   logic              frm_lvl;
   logic              frm_armed;
   logic [1:0]        act_fmt, act_wlen;
   logic [1:0]        nxt_fmt, nxt_wlen;
   logic              cfg_load;

   pcmrx_sync #(.WIDTH(3), .STAGES(SYNC_STG)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({bclk_i, fclk_i, sdata_i}),
      .q_o   (sync_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= sync_q[2];
   end
   assign bit_rise = sync_q[2] & ~bclk_d;

   pcmrx_framer #(.SLOTS(SLOTS_HALF), .SLOT_W(SLOT_W)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_rise_i (bit_rise),
      .fclk_s_i   (sync_q[1]),
      .edge_o     (frm_edge),
      .slot_o     (frm_slot),
      .lvl_prev_o (frm_lvl),
      .armed_o    (frm_armed)
   );

   // selection applies from a left-opening edge (or the first edge)
   assign cfg_load = frm_edge && (!frm_armed || (sync_q[1] == left_level(act_fmt)));
   assign nxt_fmt  = cfg_load ? fmt_i  : act_fmt;
   assign nxt_wlen = cfg_load ? wlen_i : act_wlen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_fmt  <= 2'd0;
         act_wlen <= 2'd0;
      end else begin
         act_fmt  <= nxt_fmt;
         act_wlen <= nxt_wlen;
      end
   end

   pcmrx_shift #(.OUT_W(OUT_W), .SLOTS(SLOTS_HALF), .SLOT_W(SLOT_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_rise_i  (bit_rise),
      .edge_i      (frm_edge),
      .armed_i     (frm_armed),
      .sdata_i     (sync_q[0]),
      .slot_i      (frm_slot),
      .lvl_prev_i  (frm_lvl),
      .cap_fmt_i   (nxt_fmt),
      .cap_wlen_i  (nxt_wlen),
      .emit_fmt_i  (act_fmt),
      .emit_wlen_i (act_wlen),
      .smp_o       (smp_o),
      .valid_o     (smp_valid_o),
      .right_o     (smp_right_o)
   );

   AST_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid_o |-> $past(frm_edge)); // R7
   AST_NO_EARLY_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid_o |-> $past(frm_armed)); // R9
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable(act_fmt) && $stable(act_wlen)); // R8

endmodule

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0, fclk = 1'b1, sdata = 1'b0;
   logic [1:0]  fmt = 2'd0, wlen = 2'd0;
   logic [23:0] smp;
   logic        smp_valid, smp_right;

   int checks = 0, fails = 0, cyc = 0, nvalid = 0;
   bit done = 0, running = 0;
   logic [24:0] exp_q[$];
   int          due_q[$];
   string       tag_q[$];

   // model state: selection in use, previous half's expected result
   logic [1:0]  m_fmt, m_wlen;
   logic [23:0] p_val;
   logic        p_right;
   string       p_tag;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pcm_serial_rx dut_i (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fclk_i(fclk), .sdata_i(sdata),
      .fmt_i(fmt), .wlen_i(wlen), .smp_o(smp), .smp_valid_o(smp_valid),
      .smp_right_o(smp_right)
   );

   function automatic int bits_of(input logic [1:0] w);
      return (w == 0) ? 16 : (w == 1) ? 18 : (w == 2) ? 20 : 24;
   endfunction
   function automatic logic left_lvl(input logic [1:0] f);
      return (f == 1 || f == 2);
   endfunction
   function automatic int first_of(input logic [1:0] f, input int b);
      return (f == 1) ? 0 : (f == 2) ? 32 - b : 1;
   endfunction
   function automatic string tag_of(input logic [1:0] f);
      return (f == 1) ? "R3" : (f == 2) ? "R4" : (f == 3) ? "R10" : "R2";
   endfunction
   function automatic logic [23:0] extend(input logic [23:0] w, input int b);
      int v;
      v = int'(w) & ((1 << b) - 1);
      if (v >= (1 << (b - 1))) v = v - (1 << b);
      return 24'(v);
   endfunction

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && running) begin
         if (smp_valid) nvalid++;
         if (due_q.size() > 0 && cyc == due_q[0]) begin
            logic [24:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            void'(due_q.pop_front());
            checks++;
            if (!smp_valid || smp !== e[23:0] || smp_right !== e[24]) begin
               fails++;
               $display("FAIL %s/R5/R7 cyc=%0d: got v=%0b d=%h r=%0b exp v=1 d=%h r=%0b",
                        t, cyc, smp_valid, smp, smp_right, e[23:0], e[24]);
            end
         end else if (smp_valid) begin
            checks++; fails++;
            $display("FAIL R7 cyc=%0d: strobe off schedule got d=%h exp no strobe", cyc, smp);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic play_half(input int h, input logic [23:0] word);
      logic lvl;
      int   b, f;
      lvl = ~h[0];
      // R8: selection is taken at the first edge, then only at left-opening edges
      if (h <= 1 || lvl == left_lvl(m_fmt)) begin
         m_fmt = fmt; m_wlen = wlen;
      end
      b = bits_of(m_wlen);
      f = first_of(m_fmt, b);
      for (int s = 0; s < 32; s++) begin
         logic d;
         // R6: slots outside the window carry random junk
         d = (s >= f && s < f + b) ? word[b - 1 - (s - f)] : 1'($urandom);
         @(negedge clk);
         bclk = 1'b0; fclk = lvl; sdata = d;
         repeat (3) @(negedge clk);
         bclk = 1'b1;
         if (s == 0 && h >= 2) begin
            exp_q.push_back({p_right, p_val});
            due_q.push_back(cyc + 3);
            tag_q.push_back(p_tag);
         end
         repeat (3) @(negedge clk);
      end
      p_val   = extend(word, b);
      p_right = (lvl != left_lvl(m_fmt));
      p_tag   = tag_of(m_fmt);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      finish_run();
   end

   initial begin
      m_fmt = 0; m_wlen = 0; p_val = 0; p_right = 0; p_tag = "R2";
      repeat (4) @(negedge clk);
      checks++;
      if (smp !== 24'd0 || smp_valid !== 1'b0 || smp_right !== 1'b0) begin
         fails++;
         $display("FAIL R1: got d=%h v=%0b r=%0b exp 0 0 0", smp, smp_valid, smp_right);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (smp !== 24'd0 || smp_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1: after release got d=%h v=%0b exp 0 0", smp, smp_valid);
      end
      running = 1;
      for (int h = 0; h <= 48; h++) begin
         logic [23:0] w;
         int b;
         // selection changes; some land before edges that must not load them (R8)
         case (h)
            8:  begin fmt = 2'd1; wlen = 2'd1; end
            15: begin fmt = 2'd2; wlen = 2'd2; end
            22: begin fmt = 2'd2; wlen = 2'd0; end
            29: begin fmt = 2'd0; wlen = 2'd3; end
            36: begin fmt = 2'd3; wlen = 2'd2; end
            42: begin fmt = 2'd1; wlen = 2'd3; end
            default: ;
         endcase
         b = bits_of((h <= 1 || ~h[0] == left_lvl(m_fmt)) ? wlen : m_wlen);
         w = 24'($urandom);
         if (h % 5 == 0) w = 24'(1 << (b - 1));          // most negative
         else if (h % 5 == 1) w = 24'((1 << (b - 1)) - 1); // most positive
         play_half(h, w);
         if (h == 1) begin
            checks++;
            if (nvalid != 0) begin
               fails++;
               $display("FAIL R9: got %0d strobes before first full half exp 0", nvalid);
            end
         end
      end
      repeat (12) @(negedge clk);
      checks++;
      if (due_q.size() != 0) begin
         fails++;
         $display("FAIL R7: got %0d words outstanding exp 0", due_q.size());
      end
      finish_run();
   end

endmodule